// File: doc/BRIEF.md
# System-Space Control Register Decoder

This block sits on the processor's system address space and turns each single-cycle access into an operation on one of a handful of control stores. The store is chosen by the six most significant word-address bits. Four of them are byte-wide registers:

- the current address-space context, which the translation unit uses;
- a system-enable byte, which carries the not-boot flag and the system DMA enable;
- a bus-error register;
- a diagnostic byte that drives eight front-panel LEDs.

Two other selects are local stores. One is a directly addressable 4096-word cache-tag RAM. The other is a cache-data window that only returns a fixed pattern.

A last select forwards byte accesses to an external serial controller. Every other select value is unmapped.

Requests are one cycle wide: `req_valid` with a write flag, a word address, a four-bit byte-lane mask and write data. Exactly one cycle later `rsp_valid` is high, with the read data on `rsp_rdata`; for writes that data is zero. Byte registers live in the upper byte lane. The context byte alone can also be read in the second lane. The context and enable bytes are driven out continuously to the translation logic, and the LEDs are driven out continuously.

Top module: `sysctl_decoder`

## Requirements
- R1: After reset `ctx_o` and `sysen_o` are zero, so `notboot_o` and `sdvma_o` are low (boot state), and `led_o` is 8'hFF (all LEDs dark).
- R2: Every cycle with `req_valid` high is followed in the next cycle by exactly one `rsp_valid` pulse; `rsp_valid` is low after any cycle without a request.
- R3: A write with select 3 (context), 4 (enable) or 7 (diagnostic) loads `req_wdata[31:24]` into that register whatever the lane mask. The new value shows on the outputs in the cycle after the request. A read of select 3 or 4 returns the byte in bits [31:24] with all other bits zero.
- R4: A context read whose lane mask is 4'b0100 (bit 3 of the mask is lane [31:24], bit 0 is lane [7:0]) returns the context byte in bits [23:16] with all other bits zero.
- R5: `notboot_o` follows enable bit 7 and `sdvma_o` follows enable bit 5.
- R6: `led_o` is the bitwise inverse of the diagnostic byte. A read of select 7 returns zero.
- R7: Select 8 addresses a 4096-word tag store indexed by word-address bits [11:0]; a write updates only the byte lanes set in `req_lanes`, and a read returns the stored word.
- R8: A read of select 9 (cache data) returns 32'hFFFFFFFF and a write to it changes nothing. A read of select 6 (bus error) returns zero and a write to it changes nothing.
- R9: Any other select reads zero, changes no state, and raises `unmapped_o` for exactly the response cycle.
- R10: Select 15 with word-address bit 1 clear pulses `byp_stb_o` in the request cycle. `byp_chan_o` is address bit 0. The control register is chosen when the mask is 4'b1000, and it uses lane [31:24]; otherwise the data lane [15:8] is used. `byp_wdata_o` carries that lane, and `byp_rdata_i` is returned in it. With address bit 1 set the read returns all ones and there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word address; bits [31:26] select the target |
| req_lanes | input | 4 | Byte-lane mask, bit 3 = bits [31:24] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| unmapped_o | output | 1 | Pulse with the response of an unmapped access |
| ctx_o | output | 8 | Current context to the translation unit |
| sysen_o | output | 8 | System-enable byte |
| notboot_o | output | 1 | Enable bit 7: boot state left |
| sdvma_o | output | 1 | Enable bit 5: system DMA enabled |
| led_o | output | 8 | Diagnostic LEDs, high = dark |
| byp_stb_o | output | 1 | Serial bypass access strobe |
| byp_we_o | output | 1 | Serial bypass write |
| byp_chan_o | output | 1 | Serial channel index |
| byp_ctrl_o | output | 1 | 1 = control register, 0 = data register |
| byp_wdata_o | output | 8 | Byte written to the serial controller |
| byp_rdata_i | input | 8 | Byte read from the serial controller |

## Verification
The following properties are checked on every cycle:
- the one-cycle response timing;
- the loading of the byte registers from the top lane and the inverted LED image;
- the fixed read values of the cache-data and bus-error selects;
- the unmapped strobe, its zero data and the unchanged registers after an unmapped write;
- the rule that the bypass strobe only fires for select 15.

Only the bench scenarios can show the following:
- the reset values;
- the tag store keeping data across many accesses, including partial-lane merges and the aliasing of higher address bits onto the 12-bit index;
- the lane placement of bypass read data;
- the ordering of responses that the scoreboard matches.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int SEL_W  = 6;

  localparam logic [SEL_W-1:0] SEL_CTX    = 6'h03;
  localparam logic [SEL_W-1:0] SEL_SYSEN  = 6'h04;
  localparam logic [SEL_W-1:0] SEL_BUSERR = 6'h06;
  localparam logic [SEL_W-1:0] SEL_DIAG   = 6'h07;
  localparam logic [SEL_W-1:0] SEL_TAG    = 6'h08;
  localparam logic [SEL_W-1:0] SEL_CDATA  = 6'h09;
  localparam logic [SEL_W-1:0] SEL_BYPASS = 6'h0F;

  localparam logic [LANES-1:0] MASK_SECOND_LANE = 4'b0100;
  localparam logic [LANES-1:0] MASK_TOP_LANE    = 4'b1000;

  typedef enum logic [3:0] {
    TGT_UNMAPPED,
    TGT_CTX,
    TGT_SYSEN,
    TGT_BUSERR,
    TGT_DIAG,
    TGT_TAG,
    TGT_CDATA,
    TGT_BYPASS
  } target_e;

  function automatic target_e select_target(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_CTX:    return TGT_CTX;
      SEL_SYSEN:  return TGT_SYSEN;
      SEL_BUSERR: return TGT_BUSERR;
      SEL_DIAG:   return TGT_DIAG;
      SEL_TAG:    return TGT_TAG;
      SEL_CDATA:  return TGT_CDATA;
      SEL_BYPASS: return TGT_BYPASS;
      default:    return TGT_UNMAPPED;
    endcase
  endfunction

  // Replace only the byte lanes flagged in the mask.
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [LANES-1:0]  mask);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) res[i*8 +: 8] = new_w[i*8 +: 8];
    end
    return res;
  endfunction

  function automatic logic [DATA_W-1:0] top_lane(input logic [7:0] b);
    return {b, {(DATA_W-8){1'b0}}};
  endfunction

  // The context byte can be read in the second lane when only that lane is asked for.
  function automatic logic [DATA_W-1:0] ctx_view(input logic [7:0] b, input logic [LANES-1:0] mask);
    if (mask == MASK_SECOND_LANE) return {8'h00, b, 16'h0000};
    return top_lane(b);
  endfunction

  // The serial control register uses the top lane; the data register uses lane [15:8].
  function automatic logic [DATA_W-1:0] bypass_view(input logic [7:0] b, input logic ctrl);
    if (ctrl) return top_lane(b);
    return {16'h0000, b, 8'h00};
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_lanes,
  output target_e           tgt,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic              byp_hit,
  output logic              byp_ctrl,
  output logic              byp_chan
);
  localparam int SEL_LSB = ADDR_W - SEL_W;

  assign tgt      = select_target(req_addr[ADDR_W-1:SEL_LSB]);
  assign wr_stb   = req_valid && req_write;
  assign rd_stb   = req_valid && !req_write;
  assign byp_hit  = req_valid && (tgt == TGT_BYPASS) && !req_addr[1];
  assign byp_ctrl = (req_lanes == MASK_TOP_LANE);
  assign byp_chan = req_addr[0];
endmodule

// File: rtl/sysctl_byte_regs.sv
module sysctl_byte_regs
  import sysctl_pkg::*;
#(
  parameter int NREGS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  target_e    tgt,
  input  logic [7:0] wbyte,
  output logic [7:0] ctx_q,
  output logic [7:0] sysen_q,
  output logic [7:0] diag_q
);
  function automatic target_e reg_code(input int i);
    case (i)
      0:       return TGT_CTX;
      1:       return TGT_SYSEN;
      default: return TGT_DIAG;
    endcase
  endfunction

  logic [7:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                               regs_q[g] <= 8'h00;
      else if (wr_stb && tgt == reg_code(g))    regs_q[g] <= wbyte;
    end
  end

  assign ctx_q   = regs_q[0];
  assign sysen_q = regs_q[1];
  assign diag_q  = regs_q[2];
endmodule

// File: rtl/sysctl_tag_store.sv
module sysctl_tag_store
  import sysctl_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= merge_lanes(mem[idx], wdata, lanes);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= mem[idx];
  end
endmodule

// File: rtl/sysctl_decoder.sv
module sysctl_decoder
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_IDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_lanes,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              unmapped_o,
  output logic [7:0]        ctx_o,
  output logic [7:0]        sysen_o,
  output logic              notboot_o,
  output logic              sdvma_o,
  output logic [7:0]        led_o,
  output logic              byp_stb_o,
  output logic              byp_we_o,
  output logic              byp_chan_o,
  output logic              byp_ctrl_o,
  output logic [7:0]        byp_wdata_o,
  input  logic [7:0]        byp_rdata_i
);
  localparam int SEL_LSB     = ADDR_W - SEL_W;
  localparam int NOTBOOT_BIT = 7;
  localparam int SDVMA_BIT   = 5;

  // Named internal events.
  target_e     tgt;
  logic        wr_stb, rd_stb;
  logic        byp_hit, byp_ctrl, byp_chan;
  logic        ev_tag_wr, ev_tag_rd, ev_unmapped;
  logic [7:0]  ctx_q, sysen_q, diag_q;
  logic [31:0] tag_rdata;
  logic [31:0] rd_view;
  logic [31:0] hold_q;
  logic        is_tag_q;
  logic        unused_addr_bits;

  assign unused_addr_bits = ^req_addr[SEL_LSB-1:TAG_IDX_W];

  sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_lanes (req_lanes),
    .tgt       (tgt),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .byp_hit   (byp_hit),
    .byp_ctrl  (byp_ctrl),
    .byp_chan  (byp_chan)
  );

  sysctl_byte_regs #(.NREGS(3)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .tgt     (tgt),
    .wbyte   (req_wdata[31:24]),
    .ctx_q   (ctx_q),
    .sysen_q (sysen_q),
    .diag_q  (diag_q)
  );

  assign ev_tag_wr   = wr_stb && (tgt == TGT_TAG);
  assign ev_tag_rd   = rd_stb && (tgt == TGT_TAG);
  assign ev_unmapped = req_valid && (tgt == TGT_UNMAPPED);

  sysctl_tag_store #(.IDX_W(TAG_IDX_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ev_tag_wr),
    .rd_en   (ev_tag_rd),
    .idx     (req_addr[TAG_IDX_W-1:0]),
    .lanes   (req_lanes),
    .wdata   (req_wdata),
    .rdata_q (tag_rdata)
  );

  // Read view of every target except the tag store.
  always_comb begin
    rd_view = '0;
    if (rd_stb) begin
      case (tgt)
        TGT_CTX:    rd_view = ctx_view(ctx_q, req_lanes);
        TGT_SYSEN:  rd_view = top_lane(sysen_q);
        TGT_CDATA:  rd_view = '1;
        TGT_BYPASS: rd_view = req_addr[1] ? '1 : bypass_view(byp_rdata_i, byp_ctrl);
        default:    rd_view = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      unmapped_o <= 1'b0;
      hold_q     <= '0;
      is_tag_q   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      unmapped_o <= ev_unmapped;
      hold_q     <= rd_view;
      is_tag_q   <= ev_tag_rd;
    end
  end

  assign rsp_rdata   = is_tag_q ? tag_rdata : hold_q;

  assign ctx_o       = ctx_q;
  assign sysen_o     = sysen_q;
  assign notboot_o   = sysen_q[NOTBOOT_BIT];
  assign sdvma_o     = sysen_q[SDVMA_BIT];
  assign led_o       = ~diag_q;

  assign byp_stb_o   = byp_hit;
  assign byp_we_o    = byp_hit && req_write;
  assign byp_chan_o  = byp_chan;
  assign byp_ctrl_o  = byp_ctrl;
  assign byp_wdata_o = byp_ctrl ? req_wdata[31:24] : req_wdata[15:8];
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_lanes,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              unmapped_o,
  input logic [7:0]        ctx_o,
  input logic [7:0]        sysen_o,
  input logic              notboot_o,
  input logic              sdvma_o,
  input logic [7:0]        led_o,
  input logic              byp_stb_o
);
  logic [5:0] sel;
  logic       mapped;
  assign sel    = req_addr[ADDR_W-1:ADDR_W-6];
  assign mapped = (sel == 6'h03) || (sel == 6'h04) || (sel == 6'h06) || (sel == 6'h07) ||
                  (sel == 6'h08) || (sel == 6'h09) || (sel == 6'h0F);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_ctx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && sel == 6'h03) |=> ctx_o == $past(req_wdata[31:24]));

  assert_ctx_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sel == 6'h03 && req_lanes == 4'b0100)
      |=> rsp_rdata == {8'h00, ctx_o, 16'h0000});

  assert_enable_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && sel == 6'h04)
      |=> (notboot_o == $past(req_wdata[31])) && (sdvma_o == $past(req_wdata[29])));

  assert_led_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && sel == 6'h07) |=> led_o == ~$past(req_wdata[31:24]));

  assert_cdata_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sel == 6'h09) |=> rsp_rdata == 32'hFFFF_FFFF);
  assert_buserr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sel == 6'h06) |=> rsp_rdata == 32'h0);

  assert_unmapped_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mapped) |=> unmapped_o && rsp_rdata == 32'h0);
  assert_unmapped_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mapped) |=> $stable(ctx_o) && $stable(sysen_o) && $stable(led_o));
  assert_unmapped_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_o |-> rsp_valid);

  assert_bypass_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byp_stb_o |-> (req_valid && sel == 6'h0F && !req_addr[1]));
endmodule

bind sysctl_decoder sysctl_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_lanes  (req_lanes),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .unmapped_o (unmapped_o),
  .ctx_o      (ctx_o),
  .sysen_o    (sysen_o),
  .notboot_o  (notboot_o),
  .sdvma_o    (sdvma_o),
  .led_o      (led_o),
  .byp_stb_o  (byp_stb_o)
);

// File: tb/tb_sysctl_decoder.sv
`timescale 1ns/1ps
module tb_sysctl_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_lanes = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, unmapped_o, notboot_o, sdvma_o;
  logic [31:0] rsp_rdata;
  logic [7:0]  ctx_o, sysen_o, led_o, byp_wdata_o;
  logic        byp_stb_o, byp_we_o, byp_chan_o, byp_ctrl_o;
  logic [7:0]  byp_rdata_i = 8'h6B;

  int total = 0;
  int bad = 0;

  logic [31:0] q_data[$];
  logic        q_unm[$];
  string       q_tag[$];

  always #4 clk = ~clk;  // 125 MHz

  sysctl_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_lanes(req_lanes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .unmapped_o(unmapped_o),
    .ctx_o(ctx_o), .sysen_o(sysen_o), .notboot_o(notboot_o), .sdvma_o(sdvma_o),
    .led_o(led_o), .byp_stb_o(byp_stb_o), .byp_we_o(byp_we_o), .byp_chan_o(byp_chan_o),
    .byp_ctrl_o(byp_ctrl_o), .byp_wdata_o(byp_wdata_o), .byp_rdata_i(byp_rdata_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] sel, input logic [25:0] low);
    return {sel, low};
  endfunction

  // Driver: presents one request and pushes its expected response.
  task automatic access(input bit wr, input logic [31:0] addr, input logic [3:0] lanes,
                        input logic [31:0] wdata, input logic [31:0] exp_data,
                        input bit exp_unm, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_lanes = lanes; req_wdata = wdata;
    q_data.push_back(exp_data); q_unm.push_back(exp_unm); q_tag.push_back(tag);
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Monitor: compares responses in order.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R2 unexpected response", {31'h0, rsp_valid}, 32'h0);
        end else begin
          logic [31:0] ed;
          logic        eu;
          string       t;
          ed = q_data.pop_front(); eu = q_unm.pop_front(); t = q_tag.pop_front();
          check(rsp_rdata === ed, t, rsp_rdata, ed);
          check(unmapped_o === eu, {t, " R9 unmapped flag"}, {31'h0, unmapped_o}, {31'h0, eu});
        end
      end else if (rst_n && unmapped_o) begin
        check(1'b0, "R9 flag without response", 32'h1, 32'h0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctx_o == 8'h00, "R1 ctx reset", {24'h0, ctx_o}, 32'h0);
    check(sysen_o == 8'h00 && !notboot_o && !sdvma_o, "R1 enable reset", {24'h0, sysen_o}, 32'h0);
    check(led_o == 8'hFF, "R1 leds dark", {24'h0, led_o}, 32'hFF);

    // R3 / R4 context
    access(1, mk(6'h03, 26'h0), 4'b1111, 32'h5A12_3456, 32'h0, 0, "R3 ctx write");
    check(ctx_o == 8'h5A, "R3 ctx output", {24'h0, ctx_o}, 32'h5A);
    access(0, mk(6'h03, 26'h0), 4'b1000, 32'h0, 32'h5A00_0000, 0, "R3 ctx read top lane");
    access(0, mk(6'h03, 26'h0), 4'b0100, 32'h0, 32'h005A_0000, 0, "R4 ctx read second lane");
    access(0, mk(6'h03, 26'h0), 4'b1100, 32'h0, 32'h5A00_0000, 0, "R4 ctx read wide mask");
    access(1, mk(6'h03, 26'h0), 4'b0001, 32'hC300_00FF, 32'h0, 0, "R3 ctx write low mask");
    check(ctx_o == 8'hC3, "R3 ctx takes top byte", {24'h0, ctx_o}, 32'hC3);

    // R5 enable flags
    access(1, mk(6'h04, 26'h0), 4'b1000, 32'hA000_0000, 32'h0, 0, "R5 enable write");
    check(notboot_o && sdvma_o, "R5 both flags", {30'h0, notboot_o, sdvma_o}, 32'h3);
    access(1, mk(6'h04, 26'h0), 4'b1000, 32'h8000_0000, 32'h0, 0, "R5 enable write 2");
    check(notboot_o && !sdvma_o, "R5 notboot only", {30'h0, notboot_o, sdvma_o}, 32'h2);
    access(0, mk(6'h04, 26'h0), 4'b1111, 32'h0, 32'h8000_0000, 0, "R3 enable read");

    // R6 LEDs
    access(1, mk(6'h07, 26'h0), 4'b1000, 32'h3C00_0000, 32'h0, 0, "R6 diag write");
    check(led_o == 8'hC3, "R6 led inverse", {24'h0, led_o}, 32'hC3);
    access(0, mk(6'h07, 26'h0), 4'b1111, 32'h0, 32'h0, 0, "R6 diag reads zero");

    // R7 tag store
    access(1, mk(6'h08, 26'h000), 4'b1111, 32'hDEAD_BEEF, 32'h0, 0, "R7 tag write 0");
    access(1, mk(6'h08, 26'hFFF), 4'b1111, 32'h1234_5678, 32'h0, 0, "R7 tag write 4095");
    access(1, mk(6'h08, 26'hFFF), 4'b0010, 32'h0000_AA00, 32'h0, 0, "R7 tag lane write");
    access(1, mk(6'h08, 26'h10_0005), 4'b1111, 32'h0BAD_F00D, 32'h0, 0, "R7 tag alias write");
    access(0, mk(6'h08, 26'h000), 4'b1111, 32'h0, 32'hDEAD_BEEF, 0, "R7 tag read 0");
    access(0, mk(6'h08, 26'hFFF), 4'b1111, 32'h0, 32'h1234_AA78, 0, "R7 tag lane merge");
    access(0, mk(6'h08, 26'h005), 4'b1111, 32'h0, 32'h0BAD_F00D, 0, "R7 tag index bits 11:0");

    // R8 fixed selects
    access(0, mk(6'h09, 26'h10), 4'b1111, 32'h0, 32'hFFFF_FFFF, 0, "R8 cache data read");
    access(1, mk(6'h09, 26'h10), 4'b1111, 32'h0000_0000, 32'h0, 0, "R8 cache data write");
    access(0, mk(6'h09, 26'h10), 4'b1111, 32'h0, 32'hFFFF_FFFF, 0, "R8 cache data after write");
    access(1, mk(6'h06, 26'h0), 4'b1111, 32'hFFFF_FFFF, 32'h0, 0, "R8 bus error write");
    access(0, mk(6'h06, 26'h0), 4'b1111, 32'h0, 32'h0, 0, "R8 bus error read");

    // R9 unmapped
    access(1, mk(6'h00, 26'h0), 4'b1111, 32'hFF00_0000, 32'h0, 1, "R9 unmapped write");
    check(ctx_o == 8'hC3 && sysen_o == 8'h80 && led_o == 8'hC3, "R9 state kept",
          {8'h0, ctx_o, sysen_o, led_o}, 32'h00C3_80C3);
    access(0, mk(6'h20, 26'h0), 4'b1111, 32'h0, 32'h0, 1, "R9 unmapped read");
    access(0, mk(6'h05, 26'h0), 4'b1111, 32'h0, 32'h0, 1, "R9 unmapped read 5");

    // R10 bypass
    fork
      access(1, mk(6'h0F, 26'h1), 4'b1000, 32'h4D00_0000, 32'h0, 0, "R10 bypass ctrl write");
      begin
        @(negedge clk); #1;
        check(byp_stb_o && byp_we_o && byp_chan_o && byp_ctrl_o, "R10 bypass strobe",
              {28'h0, byp_stb_o, byp_we_o, byp_chan_o, byp_ctrl_o}, 32'hF);
        check(byp_wdata_o == 8'h4D, "R10 bypass ctrl byte", {24'h0, byp_wdata_o}, 32'h4D);
      end
    join
    fork
      access(1, mk(6'h0F, 26'h0), 4'b0010, 32'h0000_7100, 32'h0, 0, "R10 bypass data write");
      begin
        @(negedge clk); #1;
        check(byp_stb_o && !byp_chan_o && !byp_ctrl_o && byp_wdata_o == 8'h71, "R10 bypass data lane",
              {20'h0, byp_stb_o, byp_chan_o, byp_ctrl_o, 1'b0, byp_wdata_o}, 32'h0000_0871);
      end
    join
    access(0, mk(6'h0F, 26'h0), 4'b1000, 32'h0, 32'h6B00_0000, 0, "R10 bypass ctrl read");
    access(0, mk(6'h0F, 26'h1), 4'b0010, 32'h0, 32'h0000_6B00, 0, "R10 bypass data read");
    fork
      access(0, mk(6'h0F, 26'h2), 4'b1000, 32'h0, 32'hFFFF_FFFF, 0, "R10 bypass high slot");
      begin
        @(negedge clk); #1;
        check(!byp_stb_o, "R10 no strobe on high slot", {31'h0, byp_stb_o}, 32'h0);
      end
    join

    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R2 all responses seen", q_data.size(), 32'h0);
    check(!rsp_valid, "R2 idle no response", {31'h0, rsp_valid}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule